// File: doc/BRIEF.md
# Strided Vector Address Generator

This block turns one vector memory instruction into a stream of per-element requests for a memory split into interleaved banks. Software hands it a byte base address, a signed stride counted in 64-bit elements, and the number of elements still to be moved. The block limits that count to the longest vector the machine holds. It then walks the element addresses in order and offers at most one request per clock cycle. Each request names the target bank, the row inside that bank, and the element index.

A bank that has just been accessed cannot take another request for a fixed number of cycles. A bank can also be held off from outside through its ready bit. When the next element points at a bank that is not free, issue stalls and keeps program order until the bank frees. Strides that revisit a bank quickly, such as a multiple of the bank count, therefore run slower than unit stride.

When a pass ends, the block reports three values for the next strip of a strip-mined loop: the length it used, the count still left, and the advanced byte pointer.

Top module: `stride_agu`

## Requirements
- R1: On an accepted start the pass length is min(MVL, n), where n is `req_len` and MVL defaults to 32. The left-over count n minus pass length appears on `remain` and the length on `pass_len`. Both are valid while `done` is high and stay held until the next accepted start.
- R2: Element i targets word address W = (base_addr >> 3) + i*stride, taken modulo 2^(ADDR_W-3), where `stride` is a two's-complement element count. `req_bank` is W[3:0] and `req_row` is W >> 4. The three low bits of `base_addr` do not affect requests.
- R3: Requests carry `req_idx` 0, 1, ... pass length - 1 in increasing order, and each index is issued exactly once per pass.
- R4: Two requests to the same bank are at least BUSY_CYC cycles apart (default 4). An element whose bank is still inside that interval is not issued, and the elements after it wait too.
- R5: No request is issued to bank b while `bank_ready[b]` is low.
- R6: While a pass runs, a request is issued in every cycle in which the next element's bank is ready and outside its busy interval. The first request can come in the cycle right after the start is accepted.
- R7: `done` is high for exactly one cycle, the cycle after the last request. `busy` is high from the cycle after an accepted start through the `done` cycle, and `req_valid` is never high while `busy` is low.
- R8: A start with `req_len` = 0 issues no request and raises `done` in the next cycle, with `pass_len` = 0, `remain` = 0 and `next_base` = `base_addr`.
- R9: `next_base` equals `base_addr` + 8*pass length, modulo 2^ADDR_W.
- R10: A start is accepted only while `busy` is low. While `busy` is high, `start`, `base_addr`, `stride` and `req_len` have no effect on the running pass or on its results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a pass (taken when not busy) |
| base_addr | input | ADDR_W | Byte address of element 0 |
| stride | input | STRIDE_W | Signed element distance in words |
| req_len | input | LEN_W | Elements still to transfer (n) |
| bank_ready | input | NBANK | Per-bank ready, bit b for bank b |
| busy | output | 1 | Pass in progress |
| req_valid | output | 1 | Element request this cycle |
| req_bank | output | BANK_W | Target bank |
| req_row | output | ADDR_W-3-BANK_W | Word address inside the bank |
| req_idx | output | IDX_W | Element index within the pass |
| done | output | 1 | One-cycle pass-complete pulse |
| pass_len | output | VL_W | Length used for the pass |
| remain | output | LEN_W | n minus pass length |
| next_base | output | ADDR_W | Byte pointer for the next strip |

## Verification
Unit stride with every bank ready is the baseline. It shows that the block issues one element per cycle and that the address arithmetic is right. Strides of 16 and 0 hit a single bank, so the busy interval sets the rate. Strides of 2, 8 and negative values cycle through fewer banks or walk backwards, which exposes errors in the spacing logic and in sign extension. Random ready masks, random lengths above and below MVL, and zero length are mixed in. Changing inputs and pulsing start in the middle of a pass shows whether a running pass is isolated from its inputs.

// File: rtl/stride_agu_pkg.sv
package stride_agu_pkg;

    // Controller phases of one pass.
    typedef enum logic [1:0] {
        AGU_IDLE = 2'd0,
        AGU_RUN  = 2'd1,
        AGU_DONE = 2'd2
    } agu_state_e;

    // Byte-to-word shift for 64-bit elements.
    localparam int unsigned ELEM_SHIFT = 3;

endpackage

// File: rtl/stride_len_clamp.sv
module stride_len_clamp #(
    parameter int unsigned LEN_W = 16,
    parameter int unsigned MVL   = 32,
    parameter int unsigned VL_W  = $clog2(MVL + 1)
) (
    input  logic [LEN_W-1:0] n_in,
    output logic [VL_W-1:0]  vl_out,
    output logic [LEN_W-1:0] rest_out
);
    localparam logic [LEN_W-1:0] MVL_L = LEN_W'(MVL);

    always_comb begin
        if (n_in > MVL_L) begin
            vl_out = VL_W'(MVL);
        end else begin
            vl_out = VL_W'(n_in);
        end
        rest_out = n_in - LEN_W'(vl_out);
    end
endmodule

// File: rtl/stride_bank_timers.sv
module stride_bank_timers #(
    parameter int unsigned NBANK    = 16,
    parameter int unsigned BANK_W   = $clog2(NBANK),
    parameter int unsigned BUSY_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit,
    input  logic [BANK_W-1:0] hit_bank,
    output logic [NBANK-1:0]  bank_free
);
    localparam int unsigned TMR_W = $clog2(BUSY_CYC + 1);
    localparam logic [TMR_W-1:0] RELOAD = TMR_W'(BUSY_CYC - 1);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [TMR_W-1:0] cnt_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q <= '0;
            end else if (hit && (hit_bank == BANK_W'(b))) begin
                cnt_q <= RELOAD;
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end

        assign bank_free[b] = (cnt_q == '0);
    end
endmodule

// File: rtl/stride_addr_seq.sv
module stride_addr_seq #(
    parameter int unsigned WORD_W   = 29,
    parameter int unsigned STRIDE_W = 16,
    parameter int unsigned IDX_W    = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [WORD_W-1:0]   load_word,
    input  logic [STRIDE_W-1:0] load_stride,
    input  logic                step,
    output logic [WORD_W-1:0]   cur_word,
    output logic [IDX_W-1:0]    cur_idx
);
    logic [WORD_W-1:0] step_q;
    logic [WORD_W-1:0] stride_ext;

    generate
        if (WORD_W > STRIDE_W) begin : g_sext
            assign stride_ext = {{(WORD_W-STRIDE_W){load_stride[STRIDE_W-1]}}, load_stride};
        end else begin : g_trunc
            assign stride_ext = load_stride[WORD_W-1:0];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_word <= '0;
            cur_idx  <= '0;
            step_q   <= '0;
        end else if (load) begin
            cur_word <= load_word;
            cur_idx  <= '0;
            step_q   <= stride_ext;
        end else if (step) begin
            cur_word <= cur_word + step_q;
            cur_idx  <= cur_idx + 1'b1;
        end
    end
endmodule

// File: rtl/stride_agu.sv
module stride_agu
    import stride_agu_pkg::*;
#(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned STRIDE_W = 16,
    parameter int unsigned LEN_W    = 16,
    parameter int unsigned NBANK    = 16,
    parameter int unsigned MVL      = 32,
    parameter int unsigned BUSY_CYC = 4,
    localparam int unsigned BANK_W  = $clog2(NBANK),
    localparam int unsigned WORD_W  = ADDR_W - ELEM_SHIFT,
    localparam int unsigned ROW_W   = WORD_W - BANK_W,
    localparam int unsigned IDX_W   = $clog2(MVL),
    localparam int unsigned VL_W    = $clog2(MVL + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [ADDR_W-1:0]   base_addr,
    input  logic [STRIDE_W-1:0] stride,
    input  logic [LEN_W-1:0]    req_len,
    input  logic [NBANK-1:0]    bank_ready,
    output logic                busy,
    output logic                req_valid,
    output logic [BANK_W-1:0]   req_bank,
    output logic [ROW_W-1:0]    req_row,
    output logic [IDX_W-1:0]    req_idx,
    output logic                done,
    output logic [VL_W-1:0]     pass_len,
    output logic [LEN_W-1:0]    remain,
    output logic [ADDR_W-1:0]   next_base
);
    agu_state_e        state_q, state_d;
    logic              accept;
    logic              fire;
    logic              last_elem;
    logic [VL_W-1:0]   vl_c;
    logic [LEN_W-1:0]  rest_c;
    logic [VL_W-1:0]   vl_q;
    logic [LEN_W-1:0]  rest_q;
    logic [ADDR_W-1:0] nbase_q;
    logic [WORD_W-1:0] cur_word;
    logic [IDX_W-1:0]  cur_idx;
    logic [NBANK-1:0]  bank_free;
    logic [BANK_W-1:0] cur_bank;

    stride_len_clamp #(
        .LEN_W (LEN_W),
        .MVL   (MVL),
        .VL_W  (VL_W)
    ) clamp_i (
        .n_in     (req_len),
        .vl_out   (vl_c),
        .rest_out (rest_c)
    );

    stride_addr_seq #(
        .WORD_W   (WORD_W),
        .STRIDE_W (STRIDE_W),
        .IDX_W    (IDX_W)
    ) seq_i (
        .clk         (clk),
        .rst         (rst),
        .load        (accept),
        .load_word   (base_addr[ADDR_W-1:ELEM_SHIFT]),
        .load_stride (stride),
        .step        (fire),
        .cur_word    (cur_word),
        .cur_idx     (cur_idx)
    );

    stride_bank_timers #(
        .NBANK    (NBANK),
        .BANK_W   (BANK_W),
        .BUSY_CYC (BUSY_CYC)
    ) timers_i (
        .clk       (clk),
        .rst       (rst),
        .hit       (fire),
        .hit_bank  (cur_bank),
        .bank_free (bank_free)
    );

    assign cur_bank  = cur_word[BANK_W-1:0];
    assign accept    = start && (state_q == AGU_IDLE);
    assign fire      = (state_q == AGU_RUN) && bank_free[cur_bank] && bank_ready[cur_bank];
    assign last_elem = ((VL_W'(cur_idx) + 1'b1) == vl_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            AGU_IDLE: begin
                if (accept) begin
                    state_d = (vl_c == '0) ? AGU_DONE : AGU_RUN;
                end
            end
            AGU_RUN: begin
                if (fire && last_elem) begin
                    state_d = AGU_DONE;
                end
            end
            AGU_DONE: state_d = AGU_IDLE;
            default:  state_d = AGU_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= AGU_IDLE;
            vl_q    <= '0;
            rest_q  <= '0;
            nbase_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                vl_q    <= vl_c;
                rest_q  <= rest_c;
                nbase_q <= base_addr + (ADDR_W'(vl_c) << ELEM_SHIFT);
            end
        end
    end

    assign busy      = (state_q != AGU_IDLE);
    assign done      = (state_q == AGU_DONE);
    assign req_valid = fire;
    assign req_bank  = cur_bank;
    assign req_row   = cur_word[WORD_W-1:BANK_W];
    assign req_idx   = cur_idx;
    assign pass_len  = vl_q;
    assign remain    = rest_q;
    assign next_base = nbase_q;
endmodule

// File: rtl/stride_agu_checker.sv
module stride_agu_checker #(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned STRIDE_W = 16,
    parameter int unsigned LEN_W    = 16,
    parameter int unsigned NBANK    = 16,
    parameter int unsigned MVL      = 32,
    parameter int unsigned BUSY_CYC = 4,
    localparam int unsigned BANK_W  = $clog2(NBANK),
    localparam int unsigned WORD_W  = ADDR_W - 3,
    localparam int unsigned ROW_W   = WORD_W - BANK_W,
    localparam int unsigned IDX_W   = $clog2(MVL),
    localparam int unsigned VL_W    = $clog2(MVL + 1)
) (
    input logic                clk,
    input logic                rst,
    input logic                start,
    input logic [WORD_W-1:0]   base_word,
    input logic [STRIDE_W-1:0] stride,
    input logic [LEN_W-1:0]    req_len,
    input logic [NBANK-1:0]    bank_ready,
    input logic                busy,
    input logic                req_valid,
    input logic [BANK_W-1:0]   req_bank,
    input logic [ROW_W-1:0]    req_row,
    input logic [IDX_W-1:0]    req_idx,
    input logic                done,
    input logic [VL_W-1:0]     pass_len
);
    logic [WORD_W-1:0] exp_word_q;
    logic [WORD_W-1:0] step_q;
    logic [VL_W-1:0]   issued_q;
    logic              took;

    assign took = start && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            exp_word_q <= '0;
            step_q     <= '0;
            issued_q   <= '0;
        end else if (took) begin
            exp_word_q <= base_word;
            step_q     <= WORD_W'($signed(stride));
            issued_q   <= '0;
        end else if (req_valid) begin
            exp_word_q <= {req_row, req_bank} + step_q;
            issued_q   <= issued_q + 1'b1;
        end
    end

    a_r2_addr_step: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> ({req_row, req_bank} == exp_word_q));

    a_r3_idx_order: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (VL_W'(req_idx) == issued_q));

    a_r3_count_at_done: assert property (@(posedge clk) disable iff (rst)
        done |-> (issued_q == pass_len));

    a_r4_no_repeat_bank: assert property (@(posedge clk) disable iff (rst)
        (req_valid && $past(req_valid) && (BUSY_CYC > 1)) |-> (req_bank != $past(req_bank)));

    a_r5_bank_ready: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> bank_ready[req_bank]);

    a_r7_valid_in_pass: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> busy);

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r8_zero_len: assert property (@(posedge clk) disable iff (rst)
        (took && (req_len == '0)) |=> (done && !req_valid));
endmodule

bind stride_agu stride_agu_checker #(
    .ADDR_W   (ADDR_W),
    .STRIDE_W (STRIDE_W),
    .LEN_W    (LEN_W),
    .NBANK    (NBANK),
    .MVL      (MVL),
    .BUSY_CYC (BUSY_CYC)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .base_word  (base_addr[ADDR_W-1:3]),
    .stride     (stride),
    .req_len    (req_len),
    .bank_ready (bank_ready),
    .busy       (busy),
    .req_valid  (req_valid),
    .req_bank   (req_bank),
    .req_row    (req_row),
    .req_idx    (req_idx),
    .done       (done),
    .pass_len   (pass_len)
);

// File: tb/stride_agu_tb_top.sv
`timescale 1ns/1ps
module stride_agu_tb_top;
    localparam int ADDR_W = 32, STRIDE_W = 16, LEN_W = 16, NBANK = 16, MVL = 32, BUSY = 4;
    localparam int BANK_W = 4, ROW_W = ADDR_W - 3 - BANK_W, IDX_W = 5, VL_W = 6;

    logic clk = 1'b0;
    logic rst;
    logic start;
    logic [ADDR_W-1:0] base_addr;
    logic [STRIDE_W-1:0] stride;
    logic [LEN_W-1:0] req_len;
    logic [NBANK-1:0] bank_ready;
    logic busy, req_valid, done;
    logic [BANK_W-1:0] req_bank;
    logic [ROW_W-1:0] req_row;
    logic [IDX_W-1:0] req_idx;
    logic [VL_W-1:0] pass_len;
    logic [LEN_W-1:0] remain;
    logic [ADDR_W-1:0] next_base;

    int n_chk = 0;
    int n_err = 0;
    longint cyc = 0;
    longint last_iss [NBANK];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    stride_agu dut_i (
        .clk(clk), .rst(rst), .start(start), .base_addr(base_addr), .stride(stride),
        .req_len(req_len), .bank_ready(bank_ready), .busy(busy), .req_valid(req_valid),
        .req_bank(req_bank), .req_row(req_row), .req_idx(req_idx), .done(done),
        .pass_len(pass_len), .remain(remain), .next_base(next_base)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_pass(input logic [31:0] b, input int s, input int n,
                            input bit rnd_ready, input bit noise);
        int vl;
        int k;
        longint w;
        int bk;
        bit fr;
        vl = (n > MVL) ? MVL : n;
        @(negedge clk);
        start = 1'b1; base_addr = b; stride = STRIDE_W'(s); req_len = LEN_W'(n);
        bank_ready = '1;
        k = 0;
        for (int guard = 0; guard < 3000; guard++) begin
            @(negedge clk);
            bank_ready = rnd_ready ? NBANK'($urandom | $urandom) : '1;
            if (noise && k < vl) begin
                // R10: scrambled inputs and start while busy
                start = 1'b1; base_addr = $urandom; stride = STRIDE_W'($urandom);
                req_len = LEN_W'($urandom % 60);
            end else begin
                start = 1'b0;
            end
            #1;
            if (k == vl) begin
                check(done == 1'b1, "R7", "done after last", done, 1);
                check(req_valid == 1'b0, "R8", "no request at done", req_valid, 0);
                check(pass_len == VL_W'(vl), "R1", "pass_len", pass_len, vl);
                check(remain == LEN_W'(n - vl), "R1", "remain", remain, n - vl);
                check(next_base == b + 32'(vl * 8), "R9", "next_base", next_base, b + 32'(vl * 8));
                break;
            end
            w = ((longint'(b) >> 3) + longint'(k) * longint'(s)) & ((64'd1 << 29) - 1);
            bk = int'(w & 15);
            fr = bank_ready[bk] && (cyc - last_iss[bk] >= BUSY);
            check(req_valid == fr, "R6", "issue when bank free", req_valid, fr);
            check(done == 1'b0, "R7", "no early done", done, 0);
            check(busy == 1'b1, "R7", "busy in pass", busy, 1);
            if (req_valid) begin
                check(req_bank == BANK_W'(bk), "R2", "bank", req_bank, bk);
                check(req_row == ROW_W'(w >> 4), "R2", "row", req_row, w >> 4);
                check(req_idx == IDX_W'(k), "R3", "index", req_idx, k);
                check(bank_ready[req_bank] == 1'b1, "R5", "ready bank", bank_ready[req_bank], 1);
                check(cyc - last_iss[req_bank] >= BUSY, "R4", "bank spacing",
                      cyc - last_iss[req_bank], BUSY);
                last_iss[req_bank] = cyc;
                k++;
            end
        end
        start = 1'b0;
        @(negedge clk); #1;
        check(done == 1'b0, "R7", "done one cycle", done, 0);
        check(busy == 1'b0, "R7", "idle after done", busy, 0);
        check(req_valid == 1'b0, "R7", "no request idle", req_valid, 0);
    endtask

    initial begin
        int unsigned sd;
        sd = $urandom(32'h5eed_0017);
        for (int i = 0; i < NBANK; i++) last_iss[i] = -100;
        rst = 1'b1; start = 1'b0; base_addr = '0; stride = '0; req_len = '0; bank_ready = '1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check(busy == 1'b0, "R7", "reset busy", busy, 0);
        check(done == 1'b0, "R7", "reset done", done, 0);
        check(req_valid == 1'b0, "R7", "reset valid", req_valid, 0);
        // directed corners
        run_pass(32'h0000_1000, 1, 20, 0, 0);    // R6 unit stride, no stall
        run_pass(32'h0000_2007, 16, 10, 0, 0);   // R4 one bank, low bits ignored (R2)
        run_pass(32'h0000_3000, 0, 6, 0, 0);     // R4 zero stride
        run_pass(32'h0000_4000, 2, 40, 0, 0);    // R1 clamp to MVL
        run_pass(32'h0000_0040, -1, 33, 0, 0);   // R2 negative stride, wrap
        run_pass(32'h0000_5000, 8, 12, 1, 0);    // R5 random ready
        run_pass(32'h0000_6000, 3, 0, 0, 0);     // R8 zero length
        run_pass(32'h0000_7000, 5, 25, 1, 1);    // R10 inputs scrambled while busy
        run_pass(32'hFFFF_FFF8, 1, 32, 0, 0);    // R9 pointer wrap
        for (int p = 0; p < 40; p++) begin
            int s;
            s = int'($urandom % 35) - 17;
            run_pass($urandom, s, int'($urandom % 70), bit'($urandom % 2), bit'($urandom % 2));
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(20 * 150000);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule